// File: doc/BRIEF.md
# Hint-Gated Hybrid Branch Direction Predictor

This block predicts the direction of conditional branches with two components. One is a per-address table of 2-bit saturating counters that learns each branch's usual direction. The other is a table of 2-bit counters whose index is the branch address XORed with a global register of recent outcomes. A third table of counters, the chooser, decides which of the two components a given branch should trust. Reading all three tables on every branch costs power, so the block also holds a small hint store. Each entry in the hint store carries a 2-bit access hint for each of the two branches that follow the branch that indexes the entry. When a hint names one component, only that component's table is enabled and read. When a hint is absent, or marks a past misprediction, the full combined lookup is done.

The fetch side presents a PC with a predict strobe. In the same cycle, combinationally, the block returns a taken/not-taken guess and one enable per table. The resolve side presents the PC of a completed branch, its real outcome and a mispredict flag. On the next clock edge the block trains the counters, shifts the global history and rewrites the affected hints. A branch's table index is PC bits [7:2]. Its hint-store index is PC bits [5:2].

Top module: `hint_gated_predictor`

## Requirements
- R1: After reset, every counter in all three tables holds 01, every hint slot holds the invalid code 10, and the global history is zero. The first prediction is therefore not taken, with all three table enables high.
- R2: A per-address counter, at index PC[7:2], steps up on a resolved taken branch and down on a not-taken one. It saturates at 3 and at 0 and never wraps. A component predicts taken when its counter's upper bit is 1.
- R3: The history-based component reads and trains the entry at PC[7:2] XOR the 6-bit global history, using the history value that is current at that moment.
- R4: Each resolve shifts the real outcome into bit 0 of the global history. The older bits move up one place and the top bit is dropped.
- R5: The chooser, at index PC[7:2], steps toward the history-based component (count up) when that component was right. It steps toward the per-address component (count down) when that one was right. It changes only when the two components disagreed. A chooser upper bit of 1 selects the history-based component.
- R6: Under hint 00, only the per-address enable is high, and the prediction is that component's upper bit.
- R7: Under hint 01, only the history-based enable is high, and the prediction is that component's upper bit.
- R8: Under hint 11 or 10, all three enables are high, and the chooser picks the prediction.
- R9: The hint for a fetched branch is taken from the second-follower slot in the entry of the branch fetched two predictions earlier, when that slot holds 00 or 01. Otherwise it is taken from the first-follower slot in the entry of the branch fetched one prediction earlier. A slot that does not exist yet after reset counts as invalid.
- R10: At resolve, the hint code is 11 if the mispredict flag is set. Otherwise it is 01 or 00, according to the chooser's upper bit before this update. The code is written into the second-follower slot of the entry for the branch resolved two resolves earlier, and into the first-follower slot of the entry for the branch resolved one resolve earlier.
- R11: Without the predict strobe, the prediction and all three enables are 0.
- R12: When a prediction and a resolve occur in the same cycle, the prediction uses the state from before that resolve's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| predValid | input | 1 | Fetch-side predict strobe |
| fetchPc | input | 16 | PC of the branch being predicted |
| resValid | input | 1 | Resolve strobe |
| resPc | input | 16 | PC of the resolved branch |
| resTaken | input | 1 | Real outcome of the resolved branch |
| resMispred | input | 1 | The resolved branch was mispredicted |
| predTaken | output | 1 | Predicted direction |
| bimEn | output | 1 | Per-address table enable |
| gshEn | output | 1 | History-based table enable |
| choEn | output | 1 | Chooser table enable |

## Verification
On every cycle, the assertions check these local invariants:
- the counters never wrap at either end;
- the global history shifts in the resolved outcome;
- a full lookup always enables both component tables;
- all enables stay low when there is no predict strobe;
- a mispredicted resolve leaves the 11 code in the first-follower slot it targets.

Other behaviour only the bench's scenarios can show, with a reference model working alongside the design:
- the ordering between the two hint slots;
- how the chooser drifts after disagreements;
- single-component access when a hint names a component, for both hint codes;
- use of pre-update state when predict and resolve share a cycle.

// File: rtl/hint_pred_pkg.sv
package hint_pred_pkg;

  typedef enum logic [1:0] {
    HINT_BIM  = 2'b00,
    HINT_GSH  = 2'b01,
    HINT_NONE = 2'b10,
    HINT_MISS = 2'b11
  } hintCode_e;

  typedef struct packed {
    logic bimEn;
    logic gshEn;
    logic choEn;
    logic forceGsh;
    logic upd;
  } accStrobe_t;

endpackage

// File: rtl/pred_ctr_table.sv
module pred_ctr_table #(
  parameter int IDX_W = 6,
  parameter logic [1:0] RST_VAL = 2'b01
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] fIdx,
  output logic [1:0]       fVal,
  input  logic [IDX_W-1:0] rIdx,
  output logic [1:0]       rVal,
  input  logic             wrEn,
  input  logic             wrUp
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] cnt [DEPTH];
  logic [1:0] nextVal;

  assign fVal = cnt[fIdx];
  assign rVal = cnt[rIdx];

  always_comb begin
    if (wrUp) nextVal = (rVal == 2'd3) ? 2'd3 : rVal + 2'd1;
    else      nextVal = (rVal == 2'd0) ? 2'd0 : rVal - 2'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cnt[i] <= RST_VAL;
    end else if (wrEn) begin
      cnt[rIdx] <= nextVal;
    end
  end

  // R2
  up_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrUp) |=> (cnt[$past(rIdx)] != 2'd0));
  // R2
  down_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrUp) |=> (cnt[$past(rIdx)] != 2'd3));

endmodule

// File: rtl/hint_pred_ctrl.sv
module hint_pred_ctrl
  import hint_pred_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int HINT_IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            predValid,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic            resMispred,
  input  logic            resChoGsh,
  output accStrobe_t      strb
);
  localparam int HDEPTH = 1 << HINT_IDX_W;

  logic [1:0] slot0 [HDEPTH];
  logic [1:0] slot1 [HDEPTH];
  logic [HINT_IDX_W-1:0] fIdx1, fIdx2, rIdx1, rIdx2;
  logic [1:0] fCnt, rCnt;
  logic [HINT_IDX_W-1:0] fIdxNow, rIdxNow;
  logic [1:0] hintFar, hintNear, hintSel, wrCode;
  logic unusedPcBits;

  assign fIdxNow = fetchPc[HINT_IDX_W+1:2];
  assign rIdxNow = resPc[HINT_IDX_W+1:2];
  assign unusedPcBits = ^{fetchPc[PC_W-1:HINT_IDX_W+2], fetchPc[1:0],
                          resPc[PC_W-1:HINT_IDX_W+2], resPc[1:0]};

  always_comb begin
    hintFar  = (fCnt == 2'd2) ? slot1[fIdx2] : HINT_NONE;
    hintNear = (fCnt != 2'd0) ? slot0[fIdx1] : HINT_NONE;
    hintSel  = hintFar[1] ? hintNear : hintFar;
  end

  always_comb begin
    strb          = '0;
    strb.upd      = resValid;
    strb.bimEn    = predValid && (hintSel[1] || hintSel == HINT_BIM);
    strb.gshEn    = predValid && (hintSel[1] || hintSel == HINT_GSH);
    strb.choEn    = predValid && hintSel[1];
    strb.forceGsh = predValid && (hintSel == HINT_GSH);
  end

  assign wrCode = resMispred ? HINT_MISS : (resChoGsh ? HINT_GSH : HINT_BIM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < HDEPTH; i++) begin
        slot0[i] <= HINT_NONE;
        slot1[i] <= HINT_NONE;
      end
      fIdx1 <= '0; fIdx2 <= '0; fCnt <= '0;
      rIdx1 <= '0; rIdx2 <= '0; rCnt <= '0;
    end else begin
      if (predValid) begin
        fIdx1 <= fIdxNow;
        fIdx2 <= fIdx1;
        fCnt  <= (fCnt == 2'd2) ? 2'd2 : fCnt + 2'd1;
      end
      if (resValid) begin
        if (rCnt == 2'd2) slot1[rIdx2] <= wrCode;
        if (rCnt != 2'd0) slot0[rIdx1] <= wrCode;
        rIdx1 <= rIdxNow;
        rIdx2 <= rIdx1;
        rCnt  <= (rCnt == 2'd2) ? 2'd2 : rCnt + 2'd1;
      end
    end
  end

  // R8
  full_reads_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.choEn |-> (strb.bimEn && strb.gshEn));
  // R11
  idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !predValid |-> !(strb.bimEn || strb.gshEn || strb.choEn));
  // R10
  miss_hint_written_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resMispred && rCnt != 2'd0) |=> (slot0[$past(rIdx1)] == HINT_MISS));

endmodule

// File: rtl/hint_pred_dpath.sv
module hint_pred_dpath
  import hint_pred_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int TBL_IDX_W = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  accStrobe_t      strb,
  input  logic [PC_W-1:0] fetchPc,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  output logic            predTaken,
  output logic            resChoGsh
);
  localparam int HIST_W = TBL_IDX_W;
  localparam int N_TBL = 3;
  localparam int T_BIM = 0;
  localparam int T_GSH = 1;
  localparam int T_CHO = 2;

  logic [HIST_W-1:0] ghr;
  logic [TBL_IDX_W-1:0] fIdx [N_TBL];
  logic [TBL_IDX_W-1:0] rIdx [N_TBL];
  logic [1:0] fVal [N_TBL];
  logic [1:0] rVal [N_TBL];
  logic wrEn [N_TBL];
  logic wrUp [N_TBL];
  logic [TBL_IDX_W-1:0] fPcIdx, rPcIdx;
  logic bimRes, gshRes, compDisagree;
  logic unusedPcBits;

  assign fPcIdx = fetchPc[TBL_IDX_W+1:2];
  assign rPcIdx = resPc[TBL_IDX_W+1:2];
  assign unusedPcBits = ^{fetchPc[PC_W-1:TBL_IDX_W+2], fetchPc[1:0],
                          resPc[PC_W-1:TBL_IDX_W+2], resPc[1:0]};

  assign bimRes       = rVal[T_BIM][1];
  assign gshRes       = rVal[T_GSH][1];
  assign compDisagree = bimRes ^ gshRes;
  assign resChoGsh    = rVal[T_CHO][1];

  always_comb begin
    fIdx[T_BIM] = fPcIdx;
    fIdx[T_GSH] = fPcIdx ^ ghr;
    fIdx[T_CHO] = fPcIdx;
    rIdx[T_BIM] = rPcIdx;
    rIdx[T_GSH] = rPcIdx ^ ghr;
    rIdx[T_CHO] = rPcIdx;
    wrEn[T_BIM] = strb.upd;
    wrUp[T_BIM] = resTaken;
    wrEn[T_GSH] = strb.upd;
    wrUp[T_GSH] = resTaken;
    wrEn[T_CHO] = strb.upd && compDisagree;
    wrUp[T_CHO] = (gshRes == resTaken);
  end

  for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
    pred_ctr_table #(.IDX_W(TBL_IDX_W), .RST_VAL(2'b01)) u_tbl (
      .clk  (clk),
      .rstN (rstN),
      .fIdx (fIdx[g]),
      .fVal (fVal[g]),
      .rIdx (rIdx[g]),
      .rVal (rVal[g]),
      .wrEn (wrEn[g]),
      .wrUp (wrUp[g])
    );
  end

  always_comb begin
    if (!(strb.bimEn || strb.gshEn)) predTaken = 1'b0;
    else if (strb.choEn)             predTaken = fVal[T_CHO][1] ? fVal[T_GSH][1] : fVal[T_BIM][1];
    else if (strb.forceGsh)          predTaken = fVal[T_GSH][1];
    else                             predTaken = fVal[T_BIM][1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ghr <= '0;
    else if (strb.upd) ghr <= {ghr[HIST_W-2:0], resTaken};
  end

  // R4
  hist_newest_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.upd |=> (ghr[0] == $past(resTaken)));
  // R4
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.upd |=> (ghr[HIST_W-1:1] == $past(ghr[HIST_W-2:0])));

endmodule

// File: rtl/hint_gated_predictor.sv
module hint_gated_predictor
  import hint_pred_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int TBL_IDX_W = 6,
  parameter int HINT_IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            predValid,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic            resTaken,
  input  logic            resMispred,
  output logic            predTaken,
  output logic            bimEn,
  output logic            gshEn,
  output logic            choEn
);
  accStrobe_t strb;
  logic resChoGsh;

  hint_pred_ctrl #(.PC_W(PC_W), .HINT_IDX_W(HINT_IDX_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .predValid  (predValid),
    .fetchPc    (fetchPc),
    .resValid   (resValid),
    .resPc      (resPc),
    .resMispred (resMispred),
    .resChoGsh  (resChoGsh),
    .strb       (strb)
  );

  hint_pred_dpath #(.PC_W(PC_W), .TBL_IDX_W(TBL_IDX_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .fetchPc   (fetchPc),
    .resPc     (resPc),
    .resTaken  (resTaken),
    .predTaken (predTaken),
    .resChoGsh (resChoGsh)
  );

  assign bimEn = strb.bimEn;
  assign gshEn = strb.gshEn;
  assign choEn = strb.choEn;

endmodule

// File: tb/hint_gated_predictor_tb.sv
`timescale 1ns/1ps
module hint_gated_predictor_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic predValid = 1'b0;
  logic [15:0] fetchPc = '0;
  logic resValid = 1'b0;
  logic [15:0] resPc = '0;
  logic resTaken = 1'b0;
  logic resMispred = 1'b0;
  logic predTaken, bimEn, gshEn, choEn;

  int nChecks = 0;
  int nFails = 0;
  int sawBimOnly = 0;
  int sawGshOnly = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hint_gated_predictor u_dut (
    .clk(clk), .rstN(rstN), .predValid(predValid), .fetchPc(fetchPc),
    .resValid(resValid), .resPc(resPc), .resTaken(resTaken), .resMispred(resMispred),
    .predTaken(predTaken), .bimEn(bimEn), .gshEn(gshEn), .choEn(choEn)
  );

  // reference model state
  logic [1:0] mBim [64];
  logic [1:0] mGsh [64];
  logic [1:0] mCho [64];
  logic [1:0] mS0 [16];
  logic [1:0] mS1 [16];
  logic [5:0] mGhr;
  logic [3:0] mF1, mF2, mR1, mR2;
  int mFc, mRc;

  // vector: {op[1:0], pc[7:0], taken, mispred}; op 1 predict, 2 resolve, 3 both
  localparam logic [11:0] VEC [16] = '{
    {2'd1, 8'h30, 1'b0, 1'b0}, {2'd2, 8'h30, 1'b1, 1'b0},
    {2'd1, 8'h34, 1'b0, 1'b0}, {2'd2, 8'h34, 1'b0, 1'b0},
    {2'd1, 8'h30, 1'b0, 1'b0}, {2'd2, 8'h30, 1'b1, 1'b1},
    {2'd1, 8'h38, 1'b0, 1'b0}, {2'd3, 8'h38, 1'b1, 1'b0},
    {2'd1, 8'h30, 1'b0, 1'b0}, {2'd2, 8'h30, 1'b1, 1'b0},
    {2'd1, 8'h34, 1'b0, 1'b0}, {2'd2, 8'h34, 1'b0, 1'b0},
    {2'd1, 8'h30, 1'b0, 1'b0}, {2'd3, 8'h30, 1'b1, 1'b0},
    {2'd1, 8'h38, 1'b0, 1'b0}, {2'd2, 8'h38, 1'b1, 1'b0}
  };

  task automatic modelReset();
    for (int i = 0; i < 64; i++) begin mBim[i] = 2'd1; mGsh[i] = 2'd1; mCho[i] = 2'd1; end
    for (int i = 0; i < 16; i++) begin mS0[i] = 2'b10; mS1[i] = 2'b10; end
    mGhr = '0; mF1 = '0; mF2 = '0; mR1 = '0; mR2 = '0; mFc = 0; mRc = 0;
  endtask

  function automatic logic [3:0] modelPredict(input logic pv, input logic [15:0] pc);
    logic [1:0] hFar, hNear, sel;
    logic [5:0] i;
    logic be, ge, ce, t;
    if (!pv) return 4'b0000;
    i = pc[7:2];
    hFar = (mFc >= 2) ? mS1[mF2] : 2'b10;
    hNear = (mFc >= 1) ? mS0[mF1] : 2'b10;
    sel = hFar[1] ? hNear : hFar;
    be = sel[1] || sel == 2'b00;
    ge = sel[1] || sel == 2'b01;
    ce = sel[1];
    if (ce) t = mCho[i][1] ? mGsh[i ^ mGhr][1] : mBim[i][1];
    else if (sel == 2'b01) t = mGsh[i ^ mGhr][1];
    else t = mBim[i][1];
    return {t, be, ge, ce};
  endfunction

  function automatic logic [1:0] satStep(input logic [1:0] v, input logic up);
    if (up) return (v == 2'd3) ? 2'd3 : v + 2'd1;
    return (v == 2'd0) ? 2'd0 : v - 2'd1;
  endfunction

  task automatic modelResolve(input logic [15:0] pc, input logic t, input logic m);
    logic [5:0] i, gi;
    logic bp, gp;
    logic [1:0] code;
    i = pc[7:2];
    gi = i ^ mGhr;
    bp = mBim[i][1];
    gp = mGsh[gi][1];
    code = m ? 2'b11 : (mCho[i][1] ? 2'b01 : 2'b00);
    if (mRc >= 2) mS1[mR2] = code;
    if (mRc >= 1) mS0[mR1] = code;
    mR2 = mR1; mR1 = pc[5:2]; if (mRc < 2) mRc++;
    if (bp != gp) mCho[i] = satStep(mCho[i], gp == t);
    mBim[i] = satStep(mBim[i], t);
    mGsh[gi] = satStep(mGsh[gi], t);
    mGhr = {mGhr[4:0], t};
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {taken,bimEn,gshEn,choEn} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic pv, input logic rv,
                      input logic [15:0] pc, input logic t, input logic m);
    logic [3:0] exp;
    @(negedge clk);
    predValid = pv; fetchPc = pc;
    resValid = rv; resPc = pc; resTaken = t; resMispred = m;
    #1;
    exp = modelPredict(pv, pc);
    if (exp[2:0] == 3'b100) sawBimOnly++;
    if (exp[2:0] == 3'b010) sawGshOnly++;
    check(req, {predTaken, bimEn, gshEn, choEn}, exp);
    @(posedge clk);
    if (rv) modelResolve(pc, t, m);
    if (pv) begin mF2 = mF1; mF1 = pc[5:2]; if (mFc < 2) mFc++; end
  endtask

  task automatic doReset();
    @(negedge clk);
    predValid = 0; resValid = 0; rstN = 0;
    modelReset();
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic finish();
    if (finished) return;
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state, first prediction does a full lookup and says not taken
    step("R1", 1, 0, 16'h0010, 0, 0);
    check("R1 explicit", {predTaken, bimEn, gshEn, choEn}, 4'b0111);
    // R11: idle cycle
    step("R11", 0, 0, 16'h0010, 0, 0);
    check("R11 explicit", {predTaken, bimEn, gshEn, choEn}, 4'b0000);

    doReset();
    for (int k = 0; k < 16; k++) begin
      logic [1:0] op;
      op = VEC[k][11:10];
      case (op)
        2'd1: step("R9", 1, 0, {8'h00, VEC[k][9:2]}, VEC[k][1], VEC[k][0]);
        2'd2: step("R11 R5", 0, 1, {8'h00, VEC[k][9:2]}, VEC[k][1], VEC[k][0]);
        default: step("R12", 1, 1, {8'h00, VEC[k][9:2]}, VEC[k][1], VEC[k][0]);
      endcase
    end

    // R2: saturation of the per-address counter
    doReset();
    for (int k = 0; k < 4; k++) step("R2", 0, 1, 16'h0040, 1, 0);
    step("R2", 1, 0, 16'h0040, 0, 0);
    check("R2 explicit", {predTaken, bimEn, gshEn, choEn}, 4'b1111);
    step("R2", 0, 1, 16'h0040, 0, 0);
    step("R2", 1, 0, 16'h0040, 0, 0);

    // R5/R6/R7/R10: steer the chooser to the history side, then replay
    doReset();
    step("R3", 0, 1, 16'h0020, 1, 0);
    step("R5", 0, 1, 16'h0020, 0, 0);
    step("R10", 0, 1, 16'h0004, 1, 0);
    step("R10", 0, 1, 16'h0008, 1, 0);
    step("R10", 0, 1, 16'h0020, 0, 0);
    step("R8", 1, 0, 16'h0004, 0, 0);
    step("R6", 1, 0, 16'h0008, 0, 0);
    check("R6 explicit", {1'b0, bimEn, gshEn, choEn}, 4'b0100);
    step("R7 R9", 1, 0, 16'h0020, 0, 0);
    check("R7 explicit", {1'b0, bimEn, gshEn, choEn}, 4'b0010);

    // R10/R8: a mispredict leaves the miss code, forcing a full lookup
    step("R10", 0, 1, 16'h0004, 1, 0);
    step("R10", 0, 1, 16'h0008, 0, 1);
    step("R4", 0, 1, 16'h0020, 1, 0);
    step("R3", 1, 0, 16'h0004, 0, 0);
    step("R8", 1, 0, 16'h0008, 0, 0);
    check("R8 explicit", {1'b0, bimEn, gshEn, choEn}, 4'b0111);
    step("R4", 1, 0, 16'h0020, 0, 0);

    check("R6 coverage", {3'b000, sawBimOnly > 0}, 4'b0001);
    check("R7 coverage", {3'b000, sawGshOnly > 0}, 4'b0001);
    finish();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish();
    end
  end

endmodule